// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of one DMA channel: a running 16-bit memory address, a running transfer count, and a page value that supplies the upper address bits. A host programs the channel through a narrow byte-wide write port. Each 16-bit value goes in as two byte writes, steered by an internal byte pointer that a dedicated command resets. Writing a base value also loads the matching running value. A mode byte sets the address direction, the automatic reload option, the transfer type and the channel enable.

An external sequencer pulses `xfer_done_i` once for each bus transfer it completes. On that pulse the channel steps its count down and its address up or down. The page bits never change on their own, so the address wraps inside one 64 KiB window. The channel reports terminal count when the count reaches zero. An external end-of-process input can stop it early. At the end of service the channel either disables itself or reloads its base values and keeps running. Two strobe-enable outputs tell the sequencer whether a read or a write strobe belongs to the current transfer. A verify transfer enables neither.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `active_o`, `tc_o`, `done_o`, `strobe_rd_o` and `strobe_wr_o` are 0, `addr_o` and `count_o` are 0, and the byte pointer points at the low byte.
- R2: Register selects on `wr_sel_i` are 0 address, 1 count, 2 page, 3 mode, and 4 clear byte pointer (data ignored). Address and count writes use one shared byte pointer: low byte first, then high byte, after which the pointer returns to low. Two cycles after each byte write, the running value equals the base value.
- R3: Each `xfer_done_i` pulse while active reduces `count_o` by one (modulo 2^16).
- R4: Each `xfer_done_i` pulse while active changes the low 16 address bits by +1 when mode bit 0 is 0, and by -1 when it is 1, wrapping modulo 2^16. The upper page bits of `addr_o` (bits 23:16) change only through a page write.
- R5: The transfer that brings the count to zero sets `tc_o` and produces a one-cycle `done_o` pulse. A programmed count of 0 therefore gives 65536 transfers.
- R6: `eop_i` while active ends the service at once with a `done_o` pulse, whatever the count. `tc_o` is not set unless the count also reached zero.
- R7: With mode bit 1 (auto-reload) clear, the channel becomes inactive at the end of service. While inactive, `xfer_done_i` and `eop_i` leave the address and count unchanged.
- R8: With mode bit 1 set, the end of service restores the running address and count from the base values, and the channel stays active.
- R9: Mode bits 3:2 select the transfer type: 00 verify, 01 write, 10 read, 11 verify. `strobe_rd_o` is high only for an active read channel, and `strobe_wr_o` only for an active write channel. A verify transfer still updates the address and count.
- R10: Mode bit 7 is the enable. A mode write sets `active_o` from bit 7 two cycles later and clears `tc_o`. `tc_o` stays set from terminal count until then or until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Host write data |
| xfer_done_i | input | 1 | One-cycle pulse per completed transfer |
| eop_i | input | 1 | External end-of-process |
| addr_o | output | 24 | Page bits over the running 16-bit address |
| count_o | output | 16 | Running transfer count |
| active_o | output | 1 | Channel enabled |
| tc_o | output | 1 | Terminal count reached (sticky) |
| done_o | output | 1 | One-cycle end-of-service pulse |
| strobe_rd_o | output | 1 | Current transfer uses a read strobe |
| strobe_wr_o | output | 1 | Current transfer uses a write strobe |

## Verification
The delicate case is a transfer pulse that arrives in the same cycle as an end-of-process while auto-reload is on. Both the step and the reload compete for the running registers, and the reload must win. The bench drives `xfer_done_i` and `eop_i` together on an armed auto-reload channel that still has count left. It expects one `done_o` pulse, the base address and count restored, and `tc_o` unaffected by that event. A second collision, the final transfer reaching zero with auto-reload set, is judged by `tc_o` rising while the running values snap back to base.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [2:0] {
        SEL_ADDR   = 3'd0,
        SEL_CNT    = 3'd1,
        SEL_PAGE   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_CLRPTR = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        XT_VERIFY = 2'b00,
        XT_WRITE  = 2'b01,
        XT_READ   = 2'b10,
        XT_RSVD   = 2'b11
    } xfer_type_e;

    localparam int MODE_DEC_BIT  = 0;
    localparam int MODE_AUTO_BIT = 1;
    localparam int MODE_TYPE_LSB = 2;
    localparam int MODE_EN_BIT   = 7;

endpackage

// File: rtl/dce_hostregs.sv
module dce_hostregs
    import dce_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [AW-1:0] base_addr_o,
    output logic [AW-1:0] base_cnt_o,
    output logic [PW-1:0] page_o,
    output logic          mode_en_o,
    output logic          mode_auto_o,
    output logic          mode_dec_o,
    output logic [1:0]    mode_type_o,
    output logic          ld_addr_o,
    output logic          ld_cnt_o,
    output logic          mode_wr_o
);

    localparam int NB   = AW / DW;
    localparam int PTRW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [AW-1:0]   base_addr;
        logic [AW-1:0]   base_cnt;
        logic [PW-1:0]   page;
        logic            en;
        logic            auto_rl;
        logic            dec;
        logic [1:0]      xtype;
        logic [PTRW-1:0] ptr;
        logic            ld_addr;
        logic            ld_cnt;
        logic            mode_wr;
    } hreg_t;

    hreg_t s_q, s_d;
    logic [PTRW-1:0] ptr_next;

    always_comb begin
        ptr_next = (s_q.ptr == PTRW'(NB - 1)) ? '0 : s_q.ptr + 1'b1;

        s_d         = s_q;
        s_d.ld_addr = 1'b0;
        s_d.ld_cnt  = 1'b0;
        s_d.mode_wr = 1'b0;

        if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_ADDR: begin
                    s_d.base_addr[s_q.ptr*DW +: DW] = wr_data_i;
                    s_d.ptr     = ptr_next;
                    s_d.ld_addr = 1'b1;
                end
                SEL_CNT: begin
                    s_d.base_cnt[s_q.ptr*DW +: DW] = wr_data_i;
                    s_d.ptr    = ptr_next;
                    s_d.ld_cnt = 1'b1;
                end
                SEL_PAGE: begin
                    s_d.page = PW'(wr_data_i);
                end
                SEL_MODE: begin
                    s_d.en      = wr_data_i[MODE_EN_BIT];
                    s_d.auto_rl = wr_data_i[MODE_AUTO_BIT];
                    s_d.dec     = wr_data_i[MODE_DEC_BIT];
                    s_d.xtype   = wr_data_i[MODE_TYPE_LSB +: 2];
                    s_d.mode_wr = 1'b1;
                end
                SEL_CLRPTR: begin
                    s_d.ptr = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base_addr_o = s_q.base_addr;
    assign base_cnt_o  = s_q.base_cnt;
    assign page_o      = s_q.page;
    assign mode_en_o   = s_q.en;
    assign mode_auto_o = s_q.auto_rl;
    assign mode_dec_o  = s_q.dec;
    assign mode_type_o = s_q.xtype;
    assign ld_addr_o   = s_q.ld_addr;
    assign ld_cnt_o    = s_q.ld_cnt;
    assign mode_wr_o   = s_q.mode_wr;

endmodule

// File: rtl/dce_xfer_state.sv
module dce_xfer_state #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr_i,
    input  logic [AW-1:0] base_cnt_i,
    input  logic          ld_addr_i,
    input  logic          ld_cnt_i,
    input  logic          mode_wr_i,
    input  logic          mode_en_i,
    input  logic          mode_auto_i,
    input  logic          mode_dec_i,
    input  logic          xfer_i,
    input  logic          eop_i,
    output logic [AW-1:0] cur_addr_o,
    output logic [AW-1:0] cur_cnt_o,
    output logic          active_o,
    output logic          tc_o,
    output logic          done_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic          active;
        logic          tc;
        logic          done;
    } xst_t;

    xst_t s_q, s_d;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] step_cnt;
    logic          hit_zero;
    logic          finish;

    always_comb begin
        step_addr = s_q.addr;
        step_cnt  = s_q.cnt;
        hit_zero  = 1'b0;
        if (xfer_i) begin
            step_cnt  = s_q.cnt - 1'b1;
            step_addr = mode_dec_i ? s_q.addr - 1'b1 : s_q.addr + 1'b1;
            hit_zero  = (step_cnt == '0);
        end
        finish = hit_zero || eop_i;

        s_d      = s_q;
        s_d.done = 1'b0;

        if (s_q.active) begin
            s_d.addr = step_addr;
            s_d.cnt  = step_cnt;
            if (finish) begin
                s_d.done = 1'b1;
                if (hit_zero) s_d.tc = 1'b1;
                if (mode_auto_i) begin
                    s_d.addr = base_addr_i;
                    s_d.cnt  = base_cnt_i;
                end else begin
                    s_d.active = 1'b0;
                end
            end
        end

        if (mode_wr_i) begin
            s_d.active = mode_en_i;
            s_d.tc     = 1'b0;
        end
        if (ld_addr_i) s_d.addr = base_addr_i;
        if (ld_cnt_i)  s_d.cnt  = base_cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_addr_o = s_q.addr;
    assign cur_cnt_o  = s_q.cnt;
    assign active_o   = s_q.active;
    assign tc_o       = s_q.tc;
    assign done_o     = s_q.done;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dce_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_sel_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             xfer_done_i,
    input  logic             eop_i,
    output logic [AW+PW-1:0] addr_o,
    output logic [AW-1:0]    count_o,
    output logic             active_o,
    output logic             tc_o,
    output logic             done_o,
    output logic             strobe_rd_o,
    output logic             strobe_wr_o
);

    logic [AW-1:0] base_addr;
    logic [AW-1:0] base_cnt;
    logic [PW-1:0] page;
    logic          mode_en;
    logic          mode_auto;
    logic          mode_dec;
    logic [1:0]    mode_type;
    logic          ld_addr;
    logic          ld_cnt;
    logic          mode_wr;
    logic [AW-1:0] cur_addr;

    dce_hostregs #(.DW(DW), .AW(AW), .PW(PW)) u_hregs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .base_addr_o (base_addr),
        .base_cnt_o  (base_cnt),
        .page_o      (page),
        .mode_en_o   (mode_en),
        .mode_auto_o (mode_auto),
        .mode_dec_o  (mode_dec),
        .mode_type_o (mode_type),
        .ld_addr_o   (ld_addr),
        .ld_cnt_o    (ld_cnt),
        .mode_wr_o   (mode_wr)
    );

    dce_xfer_state #(.AW(AW)) u_xstate (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_addr_i (base_addr),
        .base_cnt_i  (base_cnt),
        .ld_addr_i   (ld_addr),
        .ld_cnt_i    (ld_cnt),
        .mode_wr_i   (mode_wr),
        .mode_en_i   (mode_en),
        .mode_auto_i (mode_auto),
        .mode_dec_i  (mode_dec),
        .xfer_i      (xfer_done_i),
        .eop_i       (eop_i),
        .cur_addr_o  (cur_addr),
        .cur_cnt_o   (count_o),
        .active_o    (active_o),
        .tc_o        (tc_o),
        .done_o      (done_o)
    );

    assign addr_o      = {page, cur_addr};
    assign strobe_rd_o = active_o && (xfer_type_e'(mode_type) == XT_READ);
    assign strobe_wr_o = active_o && (xfer_type_e'(mode_type) == XT_WRITE);

endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [2:0]    wr_sel_i,
    input logic          xfer_done_i,
    input logic          eop_i,
    input logic [PW-1:0] page_i,
    input logic [AW-1:0] count_o,
    input logic          active_o,
    input logic          tc_o,
    input logic          done_o,
    input logic          strobe_rd_o,
    input logic          strobe_wr_o,
    input logic          ld_addr_i,
    input logic          ld_cnt_i
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && xfer_done_i && !eop_i && count_o != AW'(1) && !ld_addr_i && !ld_cnt_i)
        |=> count_o == $past(count_o) - 1'b1); // R3

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == 3'(dce_pkg::SEL_PAGE)) |=> page_i == $past(page_i)); // R4

    AST_TC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_o) |-> done_o); // R5

    AST_DONE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(active_o)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !ld_addr_i && !ld_cnt_i) |=> count_o == $past(count_o)); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe_rd_o, strobe_wr_o})); // R9

    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !(strobe_rd_o || strobe_wr_o)); // R9

endmodule

bind dma_chan_engine dce_checker #(.AW(AW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .xfer_done_i (xfer_done_i),
    .eop_i       (eop_i),
    .page_i      (addr_o[AW+PW-1:AW]),
    .count_o     (count_o),
    .active_o    (active_o),
    .tc_o        (tc_o),
    .done_o      (done_o),
    .strobe_rd_o (strobe_rd_o),
    .strobe_wr_o (strobe_wr_o),
    .ld_addr_i   (ld_addr),
    .ld_cnt_i    (ld_cnt)
);

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        xfer = 1'b0;
    logic        eop = 1'b0;
    logic [23:0] addr;
    logic [15:0] count;
    logic        active, tc, done, s_rd, s_wr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_chan_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .xfer_done_i(xfer), .eop_i(eop),
        .addr_o(addr), .count_o(count), .active_o(active), .tc_o(tc),
        .done_o(done), .strobe_rd_o(s_rd), .strobe_wr_o(s_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_ch(input logic [15:0] a, input logic [15:0] c,
                              input logic [7:0] pg, input logic [7:0] mode);
        wr(3'd4, 8'h00);
        wr(3'd0, a[7:0]);  wr(3'd0, a[15:8]);
        wr(3'd1, c[7:0]);  wr(3'd1, c[15:8]);
        wr(3'd2, pg);
        wr(3'd3, mode);
        idle(2);
    endtask

    task automatic pulse(input int n, input logic with_xfer, input logic with_eop);
        xfer = with_xfer; eop = with_eop;
        repeat (n) @(negedge clk);
        xfer = 1'b0; eop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 active", 32'(active), 0);
        chk("R1 tc", 32'(tc), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 addr", 32'(addr), 0);
        chk("R1 count", 32'(count), 0);
        chk("R1 strobes", 32'({s_rd, s_wr}), 0);
    endtask

    task automatic t_count_to_tc();
        program_ch(16'h1234, 16'd3, 8'h5A, 8'h88);
        chk("R2 addr load", 32'(addr), 32'h5A1234);
        chk("R2 count load", 32'(count), 3);
        chk("R10 enable", 32'(active), 1);
        chk("R9 read strobe", 32'({s_rd, s_wr}), 32'b10);
        pulse(1, 1, 0);
        chk("R3 count step", 32'(count), 2);
        chk("R4 addr inc", 32'(addr), 32'h5A1235);
        pulse(1, 1, 0);
        chk("R5 no done early", 32'(done), 0);
        pulse(1, 1, 0);
        chk("R5 count zero", 32'(count), 0);
        chk("R5 tc set", 32'(tc), 1);
        chk("R5 done pulse", 32'(done), 1);
        chk("R7 inactive", 32'(active), 0);
        idle(1);
        chk("R5 done one cycle", 32'(done), 0);
        pulse(1, 1, 1);
        chk("R7 idle count", 32'(count), 0);
        chk("R7 idle addr", 32'(addr), 32'h5A1237);
        chk("R9 idle strobes", 32'({s_rd, s_wr}), 0);
        chk("R5 tc sticky", 32'(tc), 1);
    endtask

    task automatic t_dec_eop();
        program_ch(16'h0001, 16'd5, 8'h12, 8'h89);
        chk("R10 tc cleared", 32'(tc), 0);
        pulse(2, 1, 0);
        chk("R4 dec wrap page kept", 32'(addr), 32'h12FFFF);
        pulse(1, 0, 1);
        chk("R6 eop done", 32'(done), 1);
        chk("R6 eop no tc", 32'(tc), 0);
        chk("R6 count kept", 32'(count), 3);
        chk("R7 off after eop", 32'(active), 0);
    endtask

    task automatic t_autoreload();
        program_ch(16'hFFFF, 16'd2, 8'h40, 8'h86);
        chk("R9 write strobe", 32'({s_rd, s_wr}), 32'b01);
        pulse(1, 1, 0);
        chk("R4 inc wrap page kept", 32'(addr), 32'h400000);
        pulse(1, 1, 0);
        chk("R8 tc on reload", 32'(tc), 1);
        chk("R8 addr restored", 32'(addr), 32'h40FFFF);
        chk("R8 count restored", 32'(count), 2);
        chk("R8 still active", 32'(active), 1);
        wr(3'd3, 8'h86);
        idle(2);
        chk("R10 mode write clears tc", 32'(tc), 0);
        pulse(1, 1, 1);
        chk("R8 collide done", 32'(done), 1);
        chk("R8 collide addr", 32'(addr), 32'h40FFFF);
        chk("R8 collide count", 32'(count), 2);
        chk("R6 collide no tc", 32'(tc), 0);
        chk("R8 collide active", 32'(active), 1);
    endtask

    task automatic t_ptr_verify();
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h11);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h22);
        wr(3'd0, 8'h33);
        wr(3'd1, 8'h07);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h80);
        idle(2);
        chk("R2 pointer clear", 32'(addr[15:0]), 32'h3322);
        chk("R2 count after clear", 32'(count), 7);
        chk("R9 verify no strobe", 32'({s_rd, s_wr}), 0);
        chk("R10 verify active", 32'(active), 1);
        pulse(1, 1, 0);
        chk("R9 verify updates count", 32'(count), 6);
        chk("R9 verify updates addr", 32'(addr[15:0]), 32'h3323);
    endtask

    task automatic t_full_window();
        program_ch(16'h0000, 16'h0000, 8'h01, 8'h88);
        pulse(65535, 1, 0);
        chk("R5 no tc before 65536", 32'(tc), 0);
        chk("R3 count one left", 32'(count), 1);
        pulse(1, 1, 0);
        chk("R5 tc at 65536", 32'(tc), 1);
        chk("R4 addr wrapped", 32'(addr), 32'h010000);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_count_to_tc();
        t_dec_eop();
        t_autoreload();
        t_ptr_verify();
        t_full_window();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule